// File: doc/BRIEF.md
# Configurable Synchronous Burst Read Sequencer

This block is the memory-device side of a synchronous burst read on a NOR-style memory. While chip enable is low, a low address-valid strobe captures a start address on a clock edge. The block then counts a programmable initial latency before it drives data words on a tri-stateable data bus. It also drives a WAIT output that tells the host whether the word on the bus is valid.

Words come from an internal read-only array whose contents are computed from the address. After the first word, the word address advances once per word and wraps at the top of the address space. The burst runs until chip enable goes high or a new address strobe restarts it.

A 16-bit configuration register, written through its own synchronous strobe, sets four things:
- the initial latency;
- the WAIT polarity;
- whether each word is held for one or two clocks;
- whether WAIT leads the wait state by one clock.

Top module: `burst_rd_seq`

## Requirements
- R1: After reset the bus is released (`dq_oe`=0), `wait_out` is high, `lat_err` is 0, and the configuration value is 16'h2800. That value means latency 5, active-low WAIT, one-clock hold and WAIT without lead.
- R2: A clock edge with `cfg_we`=1 loads `cfg_wdata` into the configuration register. The fields are:
  - latency code in bits 13:11;
  - WAIT polarity in bit 10 (1 = active high);
  - hold select in bit 9 (1 = two clocks per word);
  - WAIT lead in bit 8 (1 = lead).
- R3: An edge with `ce_n`=0 and `adv_n`=0 captures `addr_in`. Counting the cycle right after that edge as cycle 0, word 0 is first valid in cycle L, where L is the effective latency. `dq_oe` is 1 from cycle 0 until the burst ends. `dq_out` is 0 in every cycle before cycle L.
- R4: Latency codes 2 to 5 are legal, and L equals the code. Codes 0, 1, 6 and 7 set `lat_err` to 1 and give L = 5.
- R5: The asserted level of `wait_out` equals the polarity bit. Its inactive level is the inverse of that bit. While no burst is active, `wait_out` sits at the inactive level.
- R6: With the lead bit at 0, WAIT is asserted in cycles 0 to L-1 and deasserted from cycle L onward. With the lead bit at 1, WAIT is asserted in cycles 0 to L-2 and deasserted from cycle L-1 onward.
- R7: With one-clock hold, cycle L+n carries word n. With two-clock hold, cycles L+2n and L+2n+1 both carry word n. Word n is read at address (start + n) modulo 2^ADDR_W.
- R8: The word stored at address a is ((a zero-extended to 16 bits) * 16'h2F1B) ^ 16'hA5C3, truncated to 16 bits.
- R9: An edge with `ce_n`=1 ends any burst. In the next cycle `dq_oe` is 0 and `wait_out` is at its inactive level.
- R10: While `ce_n`=1, a low `adv_n` starts no burst. `dq_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 16 | Configuration write value |
| ce_n | input | 1 | Active-low chip enable |
| adv_n | input | 1 | Active-low address-valid strobe |
| addr_in | input | ADDR_W | Burst start address |
| dq_out | output | 16 | Read data |
| dq_oe | output | 1 | Data bus drive enable |
| wait_out | output | 1 | WAIT, polarity set by configuration |
| lat_err | output | 1 | Illegal latency code is programmed |

## Verification
The hardest case to reach is the WAIT edge with the lead bit set. Here WAIT deasserts one cycle before data becomes valid, so an off-by-one in the latency count shows up only for particular combinations of latency, polarity and hold.

The bench sweeps all 64 settings of the latency code, polarity, hold and lead fields, which includes every illegal code. For each setting it runs a burst and compares every cycle against a model computed from the cycle index. Start addresses are placed near the top of the array so that the bursts cross the address wrap.

// File: rtl/brs_pkg.sv
package brs_pkg;
  localparam int DW       = 16;
  localparam int LAT_LSB  = 11;
  localparam int POL_BIT  = 10;
  localparam int HOLD_BIT = 9;
  localparam int LEAD_BIT = 8;
  localparam logic [2:0] LAT_MIN = 3'd2;
  localparam logic [2:0] LAT_MAX = 3'd5;
  localparam logic [15:0] CFG_RST = 16'h2800;

  typedef struct packed {
    logic [2:0] lat_code;
    logic       pol_high;
    logic       hold2;
    logic       lead;
  } cfg_t;

  function automatic cfg_t cfg_decode(input logic [15:0] r);
    cfg_t c;
    c.lat_code = r[LAT_LSB +: 3];
    c.pol_high = r[POL_BIT];
    c.hold2    = r[HOLD_BIT];
    c.lead     = r[LEAD_BIT];
    return c;
  endfunction

  function automatic logic lat_legal(input logic [2:0] code);
    return (code >= LAT_MIN) && (code <= LAT_MAX);
  endfunction

  function automatic logic [2:0] eff_latency(input logic [2:0] code);
    return lat_legal(code) ? code : LAT_MAX;
  endfunction

  function automatic logic [DW-1:0] mem_word(input logic [15:0] a);
    logic [15:0] prod;
    prod = a * 16'h2F1B;
    return prod ^ 16'hA5C3;
  endfunction
endpackage

// File: rtl/brs_cfg_reg.sv
module brs_cfg_reg
  import brs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        we,
  input  logic [15:0] wdata,
  output cfg_t        cfg,
  output logic [2:0]  eff_lat,
  output logic        lat_err
);
  logic [15:0] cfg_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  cfg_q <= CFG_RST;
    else if (we) cfg_q <= wdata;
  end

  always_comb begin
    cfg     = cfg_decode(cfg_q);
    eff_lat = eff_latency(cfg.lat_code);
    lat_err = !lat_legal(cfg.lat_code);
  end
endmodule

// File: rtl/brs_sequencer.sv
module brs_sequencer #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [2:0]        eff_lat,
  input  logic              hold2,
  output logic              busy,
  output logic [2:0]        elapsed,
  output logic              half,
  output logic [ADDR_W-1:0] addr_q,
  output logic              lat_latch,
  output logic              word_step,
  output logic              data_valid,
  output logic              wait_state
);
  always_comb begin
    lat_latch  = !ce_n && !adv_n;
    data_valid = busy && (elapsed >= eff_lat);
    wait_state = busy && !data_valid;
    word_step  = data_valid && !lat_latch && !ce_n && (!hold2 || half);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      elapsed <= '0;
      half    <= 1'b0;
      addr_q  <= '0;
    end else if (ce_n) begin
      busy    <= 1'b0;
      elapsed <= '0;
      half    <= 1'b0;
    end else if (lat_latch) begin
      busy    <= 1'b1;
      elapsed <= '0;
      half    <= 1'b0;
      addr_q  <= addr_in;
    end else if (busy) begin
      if (!data_valid) begin
        elapsed <= elapsed + 3'd1;
      end else begin
        half <= hold2 ? !half : 1'b0;
        if (word_step) addr_q <= addr_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/brs_drive.sv
module brs_drive
  import brs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busy,
  input  logic [2:0]        elapsed,
  input  logic [2:0]        eff_lat,
  input  logic              data_valid,
  input  logic              wait_state,
  input  logic              lead,
  input  logic              pol_high,
  input  logic [ADDR_W-1:0] addr_q,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  output logic              wait_out,
  output logic              wait_act
);
  logic lead_act;

  always_comb begin
    lead_act = busy && (({1'b0, elapsed} + 4'd1) < {1'b0, eff_lat});
    wait_act = lead ? lead_act : wait_state;
    wait_out = wait_act ? pol_high : !pol_high;
    dq_oe    = busy;
    dq_out   = data_valid ? mem_word({{(16-ADDR_W){1'b0}}, addr_q}) : '0;
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_wdata,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  output logic              wait_out,
  output logic              lat_err
);
  cfg_t              cfg;
  logic [2:0]        eff_lat;
  logic              busy;
  logic [2:0]        elapsed;
  logic              half;
  logic [ADDR_W-1:0] addr_q;
  logic              lat_latch;
  logic              word_step;
  logic              data_valid;
  logic              wait_state;
  logic              wait_act;

  brs_cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(cfg_wdata),
    .cfg(cfg), .eff_lat(eff_lat), .lat_err(lat_err)
  );

  brs_sequencer #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .addr_in(addr_in),
    .eff_lat(eff_lat), .hold2(cfg.hold2),
    .busy(busy), .elapsed(elapsed), .half(half), .addr_q(addr_q),
    .lat_latch(lat_latch), .word_step(word_step),
    .data_valid(data_valid), .wait_state(wait_state)
  );

  brs_drive #(.ADDR_W(ADDR_W)) u_drv (
    .busy(busy), .elapsed(elapsed), .eff_lat(eff_lat),
    .data_valid(data_valid), .wait_state(wait_state),
    .lead(cfg.lead), .pol_high(cfg.pol_high), .addr_q(addr_q),
    .dq_out(dq_out), .dq_oe(dq_oe), .wait_out(wait_out), .wait_act(wait_act)
  );
endmodule

// File: rtl/brs_checker.sv
module brs_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              adv_n,
  input logic              cfg_we,
  input logic              dq_oe,
  input logic              wait_out,
  input logic [15:0]       dq_out,
  input logic              busy,
  input logic              pol_high,
  input logic              lead,
  input logic              hold2,
  input logic              half,
  input logic              data_valid,
  input logic              word_step,
  input logic              lat_latch,
  input logic [ADDR_W-1:0] addr_q
);
  p_ce_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |=> !dq_oe);

  p_idle_wait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (wait_out == !pol_high));

  p_wait_marks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !lead) |-> ((wait_out == pol_high) == !data_valid));

  p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (word_step && !cfg_we) |=> (addr_q == $past(addr_q) + 1'b1));

  p_hold_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hold2 && data_valid && !half && !ce_n && adv_n && !cfg_we) |=> $stable(dq_out));

  p_no_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !adv_n) |=> !busy);

  p_oe_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lat_latch |=> (dq_oe && !data_valid));
endmodule

bind burst_rd_seq brs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .adv_n(adv_n), .cfg_we(cfg_we),
  .dq_oe(dq_oe), .wait_out(wait_out), .dq_out(dq_out), .busy(busy),
  .pol_high(cfg.pol_high), .lead(cfg.lead), .hold2(cfg.hold2), .half(half),
  .data_valid(data_valid), .word_step(word_step), .lat_latch(lat_latch),
  .addr_q(addr_q)
);

// File: tb/burst_rd_seq_test.sv
module burst_rd_seq_test;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [15:0]   cfg_wdata = '0;
  logic          ce_n = 1'b1;
  logic          adv_n = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic [15:0]   dq_out;
  logic          dq_oe;
  logic          wait_out;
  logic          lat_err;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  burst_rd_seq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .ce_n(ce_n), .adv_n(adv_n), .addr_in(addr_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .wait_out(wait_out), .lat_err(lat_err)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] model_word(input int a);
    int v;
    v = ((a % 256) * 12059) % 65536;
    return 16'(v) ^ 16'hA5C3;
  endfunction

  task automatic write_cfg(input int code, input bit pol, input bit hold, input bit lead);
    @(negedge clk);
    cfg_wdata = 16'((code << 11) | (int'(pol) << 10) | (int'(hold) << 9) | (int'(lead) << 8));
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_burst(input int code, input bit pol, input bit hold,
                           input bit lead, input int start);
    int  lat;
    bit  legal;
    legal = (code >= 2) && (code <= 5);
    lat = legal ? code : 5;
    // R4: error flag from the latency field
    check(lat_err == !legal, "R4 lat_err", lat_err, !legal);
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; addr_in = AW'(start);
    for (int j = 0; j < lat + 10; j++) begin
      @(negedge clk);
      adv_n = 1'b1;
      begin
        bit vld, wact;
        int k;
        vld  = (j >= lat);
        wact = lead ? (j + 1 < lat) : (j < lat);
        check(dq_oe == 1'b1, "R3 dq_oe during burst", dq_oe, 1);
        // R5, R6: WAIT level and edge position
        check(wait_out == (wact ? pol : !pol), "R6 wait_out", wait_out,
              wact ? pol : !pol);
        if (vld) begin
          k = hold ? (j - lat) / 2 : (j - lat);
          // R7, R8: word order, hold, wrap and contents
          check(dq_out == model_word(start + k), "R7 dq_out", dq_out,
                model_word(start + k));
        end else begin
          check(dq_out == 16'h0, "R3 dq_out before latency", dq_out, 0);
        end
      end
    end
    @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    check(dq_oe == 1'b0, "R9 dq_oe after ce_n", dq_oe, 0);
    check(wait_out == !pol, "R9 wait inactive", wait_out, !pol);
    adv_n = 1'b0;
    @(negedge clk);
    adv_n = 1'b1;
    @(negedge clk);
    check(dq_oe == 1'b0, "R10 adv_n ignored", dq_oe, 0);
    check(wait_out == !pol, "R10 wait idle", wait_out, !pol);
  endtask

  initial begin
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_bad++;
    $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(dq_oe == 1'b0, "R1 dq_oe", dq_oe, 0);
    check(wait_out == 1'b1, "R1 wait_out", wait_out, 1);
    check(lat_err == 1'b0, "R1 lat_err", lat_err, 0);
    // R1: default configuration behaves as latency 5, active-low, one-clock hold, no lead
    run_burst(5, 1'b0, 1'b0, 1'b0, 40);
    // R2: sweep every field combination, including illegal codes
    for (int code = 0; code < 8; code++)
      for (int p = 0; p < 2; p++)
        for (int h = 0; h < 2; h++)
          for (int l = 0; l < 2; l++) begin
            write_cfg(code, p[0], h[0], l[0]);
            run_burst(code, p[0], h[0], l[0], 250 + code * 3 + p * 2 + h + l * 5);
          end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule